// File: doc/BRIEF.md
# Decimal Accumulator Processor Core

This block is a very small stored-program processor. It works entirely in decimal. Every memory word and the accumulator hold three decimal digits, packed as 12-bit BCD with the most significant digit in bits 11:8. A 100-word internal memory holds both the program and its data. Each word is addressed by a two-digit BCD address from 00 to 99.

Each instruction takes two clock cycles:
- In the fetch cycle, the program counter addresses memory and the word read is latched into the instruction register.
- In the execute cycle, the instruction register drives the memory address, performs a load, store, add, subtract or jump on the single accumulator, and advances the program counter.

A preload port writes memory words. While that port is active, the core is held still. A second read-only port lets the word at any address be observed. The `halted` output reports that a halt instruction has run; the core then stays frozen until reset.

Top module: `dacc_core`

## Requirements
- R1: While `rst_n` is low, `pc_value` reads 00, `acc_value` reads 000 and `halted` reads 0; memory contents are not altered by reset.
- R2: Each instruction takes exactly two clock cycles, a fetch followed by an execute, so a program of N instructions ending in halt raises `halted` N*2 rising edges after reset is released.
- R3: A word with first digit 1 loads the accumulator from the word at the address in its last two digits; first digit 2 writes the accumulator into that word.
- R4: First digit 3 adds the addressed word to the accumulator, digit by digit in BCD, modulo 1000.
- R5: First digit 4 subtracts the addressed word from the accumulator in ten's-complement form, modulo 1000 (000 - 001 = 999).
- R6: First digit 5 sets the program counter to the address in the last two digits.
- R7: First digit 6 jumps to the address only when the accumulator is 000; otherwise execution continues at the next address.
- R8: For every instruction that does not jump or halt, the program counter advances by one in decimal, and 99 is followed by 00.
- R9: The word 000 halts the core. `halted` goes to 1, the program counter keeps the address of the halt word, and the accumulator, program counter and memory stay frozen until reset.
- R10: The word 001 sets the accumulator to 000.
- R11: Every other word is a no-operation that leaves the accumulator and memory unchanged and advances the program counter by one. This covers first digits 7, 8 and 9, a first digit 0 with a nonzero middle digit, and the words 002 through 009.
- R12: When `load_en` is high, `load_data` is written to the word at `load_addr` on the rising edge. On those edges the core's program counter, accumulator and phase do not change.
- R13: `peek_data` shows the current contents of the word at `peek_addr`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Preload write strobe; holds the core still |
| load_addr | input | 8 | Preload word address, two BCD digits |
| load_data | input | 12 | Preload word, three BCD digits |
| peek_addr | input | 8 | Observation address, two BCD digits |
| peek_data | output | 12 | Word at `peek_addr` |
| acc_value | output | 12 | Accumulator, three BCD digits |
| pc_value | output | 8 | Program counter, two BCD digits |
| halted | output | 1 | High after a halt word has executed |

## Verification
A fault in the phase sequencer, or in the loading of the instruction register, changes the number of cycles until `halted` rises. This shows up on the first program run. Corrupted BCD correction in the adder shows up in the stored sum or difference as soon as the program's store word executes. A program counter that increments or wraps incorrectly sends execution to the wrong word, and the mistake then appears as a wrong final accumulator or halt address within a few instructions. Freeze faults, during halt or while preloading, appear as `pc_value` or `acc_value` moving during cycles when they must stay still.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

  localparam int unsigned WORD_DIGITS = 3;
  localparam int unsigned ADDR_DIGITS = 2;
  localparam int unsigned WORD_W      = 4 * WORD_DIGITS;
  localparam int unsigned ADDR_W      = 4 * ADDR_DIGITS;
  localparam int unsigned MEM_WORDS   = 10 ** ADDR_DIGITS;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [3:0]        digit_t;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_EXEC  = 2'd1,
    PH_HALT  = 2'd2
  } phase_e;

  // leading opcode digit
  localparam digit_t OPC_SYS   = 4'd0;
  localparam digit_t OPC_LOAD  = 4'd1;
  localparam digit_t OPC_STORE = 4'd2;
  localparam digit_t OPC_ADD   = 4'd3;
  localparam digit_t OPC_SUB   = 4'd4;
  localparam digit_t OPC_JMP   = 4'd5;
  localparam digit_t OPC_JZ    = 4'd6;

  // trailing digit of the no-address form
  localparam digit_t SYS_HALT  = 4'd0;
  localparam digit_t SYS_CLEAR = 4'd1;

  // digit-serial BCD addition with carry in, result modulo 10**WORD_DIGITS
  function automatic word_t bcd_add(input word_t a, input word_t b, input logic cin);
    word_t     r;
    logic      c;
    logic [4:0] s;
    r = '0;
    c = cin;
    for (int i = 0; i < int'(WORD_DIGITS); i++) begin
      s = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0000, c};
      if (s > 5'd9) begin
        s = s + 5'd6;
        c = 1'b1;
      end else begin
        c = 1'b0;
      end
      r[4*i +: 4] = s[3:0];
    end
    return r;
  endfunction

  // per-digit nines complement
  function automatic word_t bcd_nines(input word_t b);
    word_t r;
    r = '0;
    for (int i = 0; i < int'(WORD_DIGITS); i++) begin
      r[4*i +: 4] = 4'd9 - b[4*i +: 4];
    end
    return r;
  endfunction

  function automatic word_t bcd_sub(input word_t a, input word_t b);
    return bcd_add(a, bcd_nines(b), 1'b1);
  endfunction

  // decimal increment of an address, wrapping to all zeros
  function automatic addr_t bcd_inc(input addr_t p);
    addr_t  r;
    logic   c;
    digit_t d;
    r = '0;
    c = 1'b1;
    for (int i = 0; i < int'(ADDR_DIGITS); i++) begin
      d = p[4*i +: 4];
      if (c && d >= 4'd9) begin
        r[4*i +: 4] = 4'd0;
      end else if (c) begin
        r[4*i +: 4] = d + 4'd1;
        c = 1'b0;
      end else begin
        r[4*i +: 4] = d;
      end
    end
    return r;
  endfunction

  // BCD address to linear array index
  function automatic int unsigned bcd_index(input addr_t a);
    int unsigned idx;
    int unsigned mul;
    idx = 0;
    mul = 1;
    for (int i = 0; i < int'(ADDR_DIGITS); i++) begin
      idx = idx + 32'(a[4*i +: 4]) * mul;
      mul = mul * 10;
    end
    return idx;
  endfunction

  function automatic logic bcd_valid(input word_t w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < int'(WORD_DIGITS); i++) begin
      if (w[4*i +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/dacc_mem.sv
module dacc_mem
  import dacc_pkg::*;
#(
  parameter int unsigned DEPTH = MEM_WORDS,
  parameter int unsigned NRD   = 2
) (
  input  logic  clk,
  input  logic  wr_en,
  input  addr_t wr_addr,
  input  word_t wr_data,
  input  addr_t rd_addr [NRD],
  output word_t rd_data [NRD]
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  word_t cells_q [DEPTH];

  int unsigned      wr_full;
  logic             wr_ok;
  logic [IDX_W-1:0] wr_idx;

  always_comb begin
    wr_full = bcd_index(wr_addr);
    wr_ok   = (wr_full < DEPTH);
    wr_idx  = wr_full[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_ok) cells_q[wr_idx] <= wr_data;
  end

  for (genvar g = 0; g < int'(NRD); g++) begin : g_rd
    int unsigned      rd_full;
    logic [IDX_W-1:0] rd_idx;
    always_comb begin
      rd_full    = bcd_index(rd_addr[g]);
      rd_idx     = rd_full[IDX_W-1:0];
      rd_data[g] = (rd_full < DEPTH) ? cells_q[rd_idx] : '0;
    end
  end

endmodule

// File: rtl/dacc_alu.sv
module dacc_alu
  import dacc_pkg::*;
(
  input  word_t acc,
  input  word_t opnd,
  output word_t sum,
  output word_t diff,
  output logic  acc_zero
);

  always_comb begin
    sum      = bcd_add(acc, opnd, 1'b0);
    diff     = bcd_sub(acc, opnd);
    acc_zero = (acc == '0);
    if (bcd_valid(acc) && bcd_valid(opnd)) begin
      // R4
      sum_digits_chk: assert (bcd_valid(sum));
      // R5
      diff_roundtrip_chk: assert (bcd_add(diff, opnd, 1'b0) == acc);
    end
  end

endmodule

// File: rtl/dacc_ctrl.sv
module dacc_ctrl
  import dacc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold,
  input  word_t rd_word,
  input  word_t alu_sum,
  input  word_t alu_diff,
  input  logic  acc_zero,
  output addr_t mar_next,
  output logic  wr_en,
  output word_t wr_word,
  output word_t acc_q,
  output addr_t pc_q,
  output logic  halted,
  output logic  fetch_evt,
  output logic  exec_evt,
  output logic  halt_evt
);

  phase_e phase_q, phase_n;
  word_t  ir_q, ir_n;
  word_t  mdr_q, mdr_n;
  addr_t  mar_q;
  word_t  acc_n;
  addr_t  pc_n;
  addr_t  pc_inc;
  addr_t  ir_addr;
  digit_t op_d;
  digit_t sys_d;
  logic   mid_zero;
  logic   run;

  assign run      = !hold;
  assign op_d     = ir_q[WORD_W-1 -: 4];
  assign ir_addr  = ir_q[ADDR_W-1:0];
  assign sys_d    = ir_q[3:0];
  assign mid_zero = (ir_q[ADDR_W-1:4] == '0);
  assign pc_inc   = bcd_inc(pc_q);
  assign halted   = (phase_q == PH_HALT);

  assign fetch_evt = run && (phase_q == PH_FETCH);
  assign exec_evt  = run && (phase_q == PH_EXEC);

  always_comb begin
    unique case (phase_q)
      PH_FETCH: mar_next = pc_q;
      PH_EXEC:  mar_next = ir_addr;
      default:  mar_next = mar_q;
    endcase
  end

  always_comb begin
    phase_n  = phase_q;
    pc_n     = pc_q;
    ir_n     = ir_q;
    mdr_n    = mdr_q;
    acc_n    = acc_q;
    wr_en    = 1'b0;
    wr_word  = acc_q;
    halt_evt = 1'b0;
    if (fetch_evt) begin
      ir_n    = rd_word;
      mdr_n   = rd_word;
      phase_n = PH_EXEC;
    end else if (exec_evt) begin
      phase_n = PH_FETCH;
      pc_n    = pc_inc;
      mdr_n   = rd_word;
      case (op_d)
        OPC_LOAD:  acc_n = rd_word;
        OPC_STORE: begin
          wr_en = 1'b1;
          mdr_n = acc_q;
        end
        OPC_ADD:   acc_n = alu_sum;
        OPC_SUB:   acc_n = alu_diff;
        OPC_JMP:   pc_n  = ir_addr;
        OPC_JZ:    if (acc_zero) pc_n = ir_addr;
        OPC_SYS: begin
          if (mid_zero) begin
            case (sys_d)
              SYS_HALT: begin
                phase_n  = PH_HALT;
                pc_n     = pc_q;
                halt_evt = 1'b1;
              end
              SYS_CLEAR: acc_n = '0;
              default: ;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      acc_q   <= '0;
    end else if (fetch_evt || exec_evt) begin
      phase_q <= phase_n;
      pc_q    <= pc_n;
      ir_q    <= ir_n;
      mar_q   <= mar_next;
      mdr_q   <= mdr_n;
      acc_q   <= acc_n;
    end
  end

  // R2
  fetch_to_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_evt |=> (phase_q == PH_EXEC) && (mdr_q == ir_q));
  // R2
  exec_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_evt && !halt_evt) |=> (phase_q == PH_FETCH));
  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc_q) && $stable(acc_q) && !wr_en);
  // R12
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(pc_q) && $stable(acc_q) && $stable(phase_q));
  // R3
  store_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> exec_evt);
  // R3
  store_mdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mdr_q == $past(acc_q)) && (mar_q == $past(ir_addr)));
  // R6
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_evt && op_d == OPC_JMP) |=> (pc_q == $past(ir_addr)));
  // R7
  jz_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_evt && op_d == OPC_JZ && acc_zero) |=> (pc_q == $past(ir_addr)));

endmodule

// File: rtl/dacc_core.sv
module dacc_core
  import dacc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_en,
  input  logic [7:0]  load_addr,
  input  logic [11:0] load_data,
  input  logic [7:0]  peek_addr,
  output logic [11:0] peek_data,
  output logic [11:0] acc_value,
  output logic [7:0]  pc_value,
  output logic        halted
);

  localparam int unsigned NRD   = 2;
  localparam int unsigned RD_CPU  = 0;
  localparam int unsigned RD_PEEK = 1;

  addr_t mar_next;
  logic  cpu_we;
  word_t cpu_wdata;
  word_t acc_q;
  addr_t pc_q;
  word_t alu_sum;
  word_t alu_diff;
  logic  acc_zero;
  logic  fetch_evt;
  logic  exec_evt;
  logic  halt_evt;

  logic  mem_we;
  addr_t mem_waddr;
  word_t mem_wdata;
  addr_t rd_addr [NRD];
  word_t rd_data [NRD];

  assign mem_we    = load_en || cpu_we;
  assign mem_waddr = load_en ? addr_t'(load_addr) : mar_next;
  assign mem_wdata = load_en ? word_t'(load_data) : cpu_wdata;
  assign rd_addr[RD_CPU]  = mar_next;
  assign rd_addr[RD_PEEK] = addr_t'(peek_addr);

  dacc_mem #(.DEPTH(MEM_WORDS), .NRD(NRD)) u_mem (
    .clk     (clk),
    .wr_en   (mem_we),
    .wr_addr (mem_waddr),
    .wr_data (mem_wdata),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  dacc_alu u_alu (
    .acc      (acc_q),
    .opnd     (rd_data[RD_CPU]),
    .sum      (alu_sum),
    .diff     (alu_diff),
    .acc_zero (acc_zero)
  );

  dacc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (load_en),
    .rd_word   (rd_data[RD_CPU]),
    .alu_sum   (alu_sum),
    .alu_diff  (alu_diff),
    .acc_zero  (acc_zero),
    .mar_next  (mar_next),
    .wr_en     (cpu_we),
    .wr_word   (cpu_wdata),
    .acc_q     (acc_q),
    .pc_q      (pc_q),
    .halted    (halted),
    .fetch_evt (fetch_evt),
    .exec_evt  (exec_evt),
    .halt_evt  (halt_evt)
  );

  assign peek_data = 12'(rd_data[RD_PEEK]);
  assign acc_value = 12'(acc_q);
  assign pc_value  = 8'(pc_q);

  // R12
  load_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> !cpu_we && !fetch_evt && !exec_evt);
  // R9
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt |=> halted && (pc_value == $past(pc_value)));

endmodule

// File: tb/dacc_core_bench.sv
module dacc_core_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [11:0] load_data = '0;
  logic [7:0]  peek_addr = '0;
  logic [11:0] peek_data;
  logic [11:0] acc_value;
  logic [7:0]  pc_value;
  logic        halted;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dacc_core u_dacc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_addr (load_addr),
    .load_data (load_data),
    .peek_addr (peek_addr),
    .peek_data (peek_data),
    .acc_value (acc_value),
    .pc_value  (pc_value),
    .halted    (halted)
  );

  function automatic logic [11:0] w3(input int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic logic [7:0] a2(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic poke(input logic [7:0] a, input logic [11:0] d);
    load_en   = 1'b1;
    load_addr = a;
    load_data = d;
    @(negedge clk);
    load_en   = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [11:0] d);
    peek_addr = a;
    #1;
    d = peek_data;
  endtask

  task automatic launch(output int cyc);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [11:0] rd;

    @(negedge clk);
    // R1 reset state
    chk("R1 pc", 32'(pc_value), 32'h00);
    chk("R1 acc", 32'(acc_value), 32'h000);
    chk("R1 halted", 32'(halted), 32'd0);

    for (int i = 0; i < 100; i++) poke(a2(i), 12'h000);

    // arithmetic sweep: load a, sub b, store 13, load a, add b, store 12, halt
    for (int a = 0; a < 1000; a += 27) begin
      for (int b = 0; b < 1000; b += 37) begin
        rst_n = 1'b0;
        poke(8'h00, 12'h110);
        poke(8'h01, 12'h411);
        poke(8'h02, 12'h213);
        poke(8'h03, 12'h110);
        poke(8'h04, 12'h311);
        poke(8'h05, 12'h212);
        poke(8'h06, 12'h000);
        poke(8'h10, w3(a));
        poke(8'h11, w3(b));
        poke(8'h12, 12'hEEE);
        poke(8'h13, 12'hEEE);
        launch(cyc);
        chk("R2 cycles", 32'(cyc), 32'd14);
        peek(8'h12, rd);
        chk("R4 sum", 32'(rd), 32'(w3((a + b) % 1000)));
        peek(8'h13, rd);
        chk("R5 diff", 32'(rd), 32'(w3((a - b + 1000) % 1000)));
        chk("R3 acc", 32'(acc_value), 32'(w3((a + b) % 1000)));
        chk("R9 halt pc", 32'(pc_value), 32'h06);
      end
    end

    // jump, conditional jump both ways, wrap 99 -> 00
    rst_n = 1'b0;
    for (int i = 0; i < 100; i++) poke(a2(i), 12'h000);
    poke(8'h00, 12'h650);
    poke(8'h50, 12'h110);
    poke(8'h51, 12'h598);
    poke(8'h98, 12'h700);
    poke(8'h99, 12'h800);
    poke(8'h10, 12'h007);
    launch(cyc);
    chk("R8 wrap instr count", 32'(cyc), 32'd14);
    chk("R7 jz not taken pc", 32'(pc_value), 32'h01);
    chk("R6 jump acc", 32'(acc_value), 32'h007);
    chk("R9 halted", 32'(halted), 32'd1);

    // no-ops and clear
    rst_n = 1'b0;
    poke(8'h00, 12'h110);
    poke(8'h01, 12'h713);
    poke(8'h02, 12'h813);
    poke(8'h03, 12'h913);
    poke(8'h04, 12'h042);
    poke(8'h05, 12'h005);
    poke(8'h06, 12'h211);
    poke(8'h07, 12'h001);
    poke(8'h08, 12'h212);
    poke(8'h09, 12'h000);
    poke(8'h10, 12'h123);
    poke(8'h11, 12'h999);
    poke(8'h12, 12'h999);
    poke(8'h13, 12'h456);
    poke(8'h42, 12'h888);
    launch(cyc);
    chk("R11 nop cycles", 32'(cyc), 32'd20);
    peek(8'h13, rd);
    chk("R11 nop mem13", 32'(rd), 32'h456);
    peek(8'h42, rd);
    chk("R11 nop mem42", 32'(rd), 32'h888);
    peek(8'h11, rd);
    chk("R11 acc kept", 32'(rd), 32'h123);
    peek(8'h12, rd);
    chk("R10 cleared store", 32'(rd), 32'h000);
    chk("R10 acc", 32'(acc_value), 32'h000);
    chk("R9 pc at halt", 32'(pc_value), 32'h09);

    // R9 frozen while halted
    repeat (10) @(negedge clk);
    chk("R9 frozen pc", 32'(pc_value), 32'h09);
    chk("R9 frozen acc", 32'(acc_value), 32'h000);
    chk("R9 still halted", 32'(halted), 32'd1);

    // R10 clear from a nonzero value, R7 jz taken after clear
    rst_n = 1'b0;
    poke(8'h00, 12'h110);
    poke(8'h01, 12'h001);
    poke(8'h02, 12'h630);
    poke(8'h03, 12'h000);
    poke(8'h30, 12'h000);
    poke(8'h10, 12'h555);
    launch(cyc);
    chk("R7 jz taken pc", 32'(pc_value), 32'h30);
    chk("R10 clear acc", 32'(acc_value), 32'h000);

    // R12 hold while preloading, R13 peek
    rst_n = 1'b0;
    poke(8'h00, 12'h110);
    poke(8'h01, 12'h000);
    poke(8'h10, 12'h321);
    rst_n     = 1'b1;
    load_en   = 1'b1;
    load_addr = 8'h20;
    load_data = 12'h654;
    repeat (5) @(negedge clk);
    chk("R12 hold pc", 32'(pc_value), 32'h00);
    chk("R12 hold acc", 32'(acc_value), 32'h000);
    chk("R12 hold halted", 32'(halted), 32'd0);
    load_en = 1'b0;
    peek(8'h20, rd);
    chk("R13 peek", 32'(rd), 32'h654);
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    chk("R12 run after hold", 32'(cyc), 32'd4);
    chk("R3 load acc", 32'(acc_value), 32'h321);
    chk("R8 pc", 32'(pc_value), 32'h01);

    // R1 reset returns registers, keeps memory
    rst_n = 1'b0;
    #1;
    chk("R1 pc again", 32'(pc_value), 32'h00);
    chk("R1 acc again", 32'(acc_value), 32'h000);
    chk("R1 halted again", 32'(halted), 32'd0);
    peek(8'h10, rd);
    chk("R1 memory kept", 32'(rd), 32'h321);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule